// File: doc/BRIEF.md
# Sequenced-Write Watchdog Timer

This block is a watchdog timer reached through one 32-bit control register on a plain register bus. Software holds a 24-bit reload value in the low bits of the register. A 32-bit down-counter, clocked by the bus clock, is loaded with that value shifted left by eight. While the timer runs, the counter steps down once per clock. When it reaches zero, a sticky expiry output rises.

Two actions, turning the timer on or off and servicing it, never follow from a single write. Each has its own 2-bit field in the register. An action takes place only when two consecutive register writes put the code 1 and then the code 2 into that field. Any other write pattern cancels the half-finished sequence. A stray or corrupted write therefore cannot stop the timer or keep it alive. Every write also replaces the stored reload value. The counter loads the reload value carried by the write that completes the sequence.

Top module: `wdog_seq_top`

## Requirements
- R1: After a synchronous active-low reset, the timer is disabled, `reg_rdata` reads 0 and `expired` is 0.
- R2: `reg_rdata` bit 31 is the live enabled state, bits 30:24 read as 0, and bits 23:0 return the reload value of the most recent write.
- R3: The toggle field sits at bits 25:24. When a write holding 1 there is followed by the next write holding 2 there, the enabled state flips at that second write.
- R4: Each of the two fields breaks its sequence on any write that puts 0 or 3 in it, and on a 2 that has no 1 in the previous write. Clock cycles with no write leave a half-finished sequence pending.
- R5: The toggle field and the service field (bits 27:26) each track their own sequence, so a write's content in one field does not affect the other field's progress.
- R6: When a toggle sequence completes while disabled, the counter loads the completing write's bits 23:0 shifted left by 8. With a loaded value L and no later write, `expired` becomes 1 at the (L+1)th clock edge after the completing write.
- R7: A completed service sequence (1 then 2 in bits 27:26) reloads the counter from the completing write while the timer is enabled. It has no effect while the timer is disabled, and it is ignored when the same write also completes a toggle.
- R8: A toggle sequence that completes while enabled stops the counter, disables the timer and clears `expired` at that clock edge.
- R9: Once set, `expired` stays 1 while the timer is enabled, even after a service, and the counter holds at zero without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the counter counts it |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | One-cycle write strobe for the control register |
| reg_wdata | input | 32 | Write data: service field 27:26, toggle field 25:24, reload 23:0 |
| reg_rdata | output | 32 | Read data: enabled 31, zeros 30:24, reload 23:0 |
| expired | output | 1 | Sticky expiry flag |

## Verification
The assertions assume that each write is a single-cycle strobe with data that is stable in that cycle. They also assume that reset is held for at least one clock edge before the first write. The bench drives every write as a one-cycle strobe, changing inputs only on the falling clock edge. Its random writes use small reload values, so that expiry, service after expiry and every ordering of field codes all occur within the run. Directed steps hit the exact expiry edge, broken sequences and service while disabled.

// File: rtl/wdog_pkg.sv
// Shared constants for the sequenced-write watchdog.
// Assumes a 32-bit register with the two 2-bit action fields above the reload value.
package wdog_pkg;
    localparam int FIELD_W  = 2;
    localparam int TGL_LSB  = 24;   // toggle (enable/disable) field
    localparam int SVC_LSB  = 26;   // service (reload) field
    localparam int N_FIELDS = 2;

    localparam logic [FIELD_W-1:0] SEQ_ARM  = 2'd1;
    localparam logic [FIELD_W-1:0] SEQ_FIRE = 2'd2;

    typedef enum logic [0:0] {ACT_TOGGLE = 1'b0, ACT_SERVICE = 1'b1} act_e;
endpackage

// File: rtl/wdog_seq_det.sv
// Two-write sequence detector for one action field.
// Arms on a write carrying SEQ_ARM; fires on the very next write carrying SEQ_FIRE.
// Any other write clears the armed state; idle cycles keep it.
module wdog_seq_det
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FIELD_W-1:0] field,
    output logic               fire
);
    logic pending;

    // Track whether the previous write armed this field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (wr)
            pending <= (field == SEQ_ARM);
    end

    assign fire = wr && (field == SEQ_FIRE) && pending;

    a_r4_cancel_on_other: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && field != SEQ_ARM) |=> !pending);
    a_r4_arm_on_code1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && field == SEQ_ARM) |=> pending);
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(pending));
endmodule

// File: rtl/wdog_countdown.sv
// Watchdog state: enabled flag, 32-bit down-counter and sticky expiry.
// Assumes toggle/service pulses are single-cycle and load_val is valid with them.
module wdog_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgl,
    input  logic             svc,
    input  logic [CNT_W-1:0] load_val,
    output logic             enabled,
    output logic             expired
);
    logic [CNT_W-1:0] count;

    // Apply toggle, then service, else count down and flag expiry at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
            expired <= 1'b0;
            count   <= '0;
        end else if (tgl) begin
            if (!enabled) begin
                enabled <= 1'b1;
                count   <= load_val;
            end else begin
                enabled <= 1'b0;
                expired <= 1'b0;
            end
        end else if (svc && enabled) begin
            count <= load_val;
        end else if (enabled) begin
            if (count == '0)
                expired <= 1'b1;
            else
                count <= count - 1'b1;
        end
    end

    a_r6_enable_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl && !enabled) |=> (enabled && count == $past(load_val)));
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl && enabled) |=> (!enabled && !expired));
    a_r7_service_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && enabled && !tgl) |=> (count == $past(load_val)));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && enabled && !tgl) |=> expired);
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && count == '0 && !tgl && !svc) |=> (count == '0));
    a_r7_disabled_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !tgl) |=> (!enabled && $stable(count)));
endmodule

// File: rtl/wdog_seq_top.sv
// Sequenced-write watchdog: one control register, two sequence detectors,
// a reload holding register and the countdown core.
// Assumes single-cycle write strobes; reads are combinational from state.
module wdog_seq_top
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RELOAD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              expired
);
    localparam int SHIFT  = DATA_W - RELOAD_W;
    localparam int GAP_W  = DATA_W - 1 - RELOAD_W;
    localparam int HI_LSB = SVC_LSB + FIELD_W;

    logic [RELOAD_W-1:0] reload_q;
    logic [DATA_W-1:0]   load_val;
    logic [N_FIELDS-1:0] fire;
    logic                enabled;
    logic                unused_hi;

    assign unused_hi = ^reg_wdata[DATA_W-1:HI_LSB];

    // Hold the reload value of the latest write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (reg_wr)
            reload_q <= reg_wdata[RELOAD_W-1:0];
    end

    assign load_val = {reg_wdata[RELOAD_W-1:0], {SHIFT{1'b0}}};

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_seq
        localparam int LSB = (i == int'(ACT_SERVICE)) ? SVC_LSB : TGL_LSB;
        wdog_seq_det u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (reg_wr),
            .field (reg_wdata[LSB +: FIELD_W]),
            .fire  (fire[i])
        );
    end

    wdog_countdown #(.CNT_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgl      (fire[ACT_TOGGLE]),
        .svc      (fire[ACT_SERVICE]),
        .load_val (load_val),
        .enabled  (enabled),
        .expired  (expired)
    );

    assign reg_rdata = {enabled, {GAP_W{1'b0}}, reload_q};

    a_r2_reload_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[RELOAD_W-1:0] == $past(reg_wdata[RELOAD_W-1:0])));
    a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        fire[ACT_TOGGLE] |=> (reg_rdata[DATA_W-1] != $past(reg_rdata[DATA_W-1])));
    a_r1_expired_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> reg_rdata[DATA_W-1]);
endmodule

// File: tb/sim_wdog_seq_top.sv
// Bench: directed corner cases plus seeded random writes against a bench model.
module sim_wdog_seq_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        expired;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    logic        m_en, m_exp, p_tgl, p_svc;
    logic [31:0] m_cnt;
    logic [23:0] m_rel;

    always #2.5 clk = ~clk;

    wdog_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .expired(expired)
    );

    function automatic logic [31:0] mk(input logic [1:0] svc, input logic [1:0] tgl,
                                       input logic [23:0] rel);
        return {4'h0, svc, tgl, rel};
    endfunction

    function automatic logic [31:0] exp_rd();
        return {m_en, 7'h00, m_rel};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    // advance model by one clock edge using the current inputs
    task automatic model_step();
        logic t, s;
        logic [31:0] ld;
        t = 1'b0; s = 1'b0; ld = '0;
        if (!rst_n) begin
            m_en = 0; m_exp = 0; p_tgl = 0; p_svc = 0; m_cnt = 0; m_rel = 0;
        end else begin
            if (reg_wr) begin
                t = (reg_wdata[25:24] == 2'd2) && p_tgl;
                s = (reg_wdata[27:26] == 2'd2) && p_svc;
                p_tgl = (reg_wdata[25:24] == 2'd1);
                p_svc = (reg_wdata[27:26] == 2'd1);
                m_rel = reg_wdata[23:0];
                ld = {reg_wdata[23:0], 8'h00};
            end
            if (t) begin
                if (!m_en) begin m_en = 1; m_cnt = ld; end
                else begin m_en = 0; m_exp = 0; end
            end else if (s && m_en) begin
                m_cnt = ld;
            end else if (m_en) begin
                if (m_cnt == 0) m_exp = 1;
                else m_cnt = m_cnt - 1;
            end
        end
    endtask

    // one clock: inputs already set at negedge; compare at following negedge
    task automatic cyc(input logic wr, input logic [31:0] d);
        reg_wr = wr;
        reg_wdata = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        reg_wr = 1'b0;
        check(reg_rdata == exp_rd(), "R2 model rdata", reg_rdata, exp_rd());
        check(expired == m_exp, "R9 model expired", {31'h0, expired}, {31'h0, m_exp});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, reg_wdata);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        @(negedge clk);
        cyc(1'b0, '0);
        cyc(1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
        check(expired == 1'b0, "R1 expired", {31'h0, expired}, 32'h0);

        // R3 enable sequence with reload 1 -> L = 256
        cyc(1'b1, mk(2'd0, 2'd1, 24'h000001));
        cyc(1'b1, mk(2'd0, 2'd2, 24'h000001));
        check(reg_rdata == 32'h8000_0001, "R3 enabled", reg_rdata, 32'h8000_0001);
        // R6 expiry exactly at edge L+1
        idle(256);
        check(expired == 1'b0, "R6 not yet", {31'h0, expired}, 32'h0);
        idle(1);
        check(expired == 1'b1, "R6 expiry edge", {31'h0, expired}, 32'h1);
        // R9 sticky, also across a service
        idle(40);
        cyc(1'b1, mk(2'd1, 2'd0, 24'h000002));
        cyc(1'b1, mk(2'd2, 2'd0, 24'h000002));
        idle(5);
        check(expired == 1'b1, "R9 sticky", {31'h0, expired}, 32'h1);
        // R8 disable clears
        cyc(1'b1, mk(2'd0, 2'd1, 24'h000003));
        cyc(1'b1, mk(2'd0, 2'd2, 24'h000003));
        check(expired == 1'b0, "R8 cleared", {31'h0, expired}, 32'h0);
        check(reg_rdata == 32'h0000_0003, "R8 disabled", reg_rdata, 32'h0000_0003);

        // R4 broken sequences: 1,0,2 and a lone 2, also 1,3,2
        cyc(1'b1, mk(2'd0, 2'd1, 24'h10));
        cyc(1'b1, mk(2'd0, 2'd0, 24'h10));
        cyc(1'b1, mk(2'd0, 2'd2, 24'h10));
        check(reg_rdata[31] == 1'b0, "R4 broken by 0", reg_rdata, 32'h10);
        cyc(1'b1, mk(2'd0, 2'd1, 24'h11));
        cyc(1'b1, mk(2'd0, 2'd3, 24'h11));
        cyc(1'b1, mk(2'd0, 2'd2, 24'h11));
        check(reg_rdata[31] == 1'b0, "R4 broken by 3", reg_rdata, 32'h11);
        // R4 idle cycles keep pending
        cyc(1'b1, mk(2'd0, 2'd1, 24'h12));
        idle(7);
        cyc(1'b1, mk(2'd0, 2'd2, 24'h12));
        check(reg_rdata == 32'h8000_0012, "R4 idle keeps pending", reg_rdata, 32'h8000_0012);

        // R5 service field activity does not disturb toggle progress
        cyc(1'b1, mk(2'd1, 2'd1, 24'h12));
        cyc(1'b1, mk(2'd3, 2'd2, 24'h12));
        check(reg_rdata[31] == 1'b0, "R5 toggle despite svc", reg_rdata, 32'h12);

        // R7 service while disabled has no effect
        cyc(1'b1, mk(2'd1, 2'd0, 24'h0));
        cyc(1'b1, mk(2'd2, 2'd0, 24'h0));
        idle(20);
        check(expired == 1'b0 && reg_rdata == 32'h0, "R7 service while disabled",
              reg_rdata, 32'h0);

        // R7 service while enabled postpones expiry (reload 1 then service reload 2)
        cyc(1'b1, mk(2'd0, 2'd1, 24'h1));
        cyc(1'b1, mk(2'd1, 2'd2, 24'h1));
        idle(100);
        cyc(1'b1, mk(2'd2, 2'd0, 24'h2));
        idle(300);
        check(expired == 1'b0, "R7 service postponed", {31'h0, expired}, 32'h0);
        idle(300);
        check(expired == 1'b1, "R7 expiry after service", {31'h0, expired}, 32'h1);

        // R7 same write completes toggle and service: toggle governs (disables)
        cyc(1'b1, mk(2'd1, 2'd1, 24'h5));
        cyc(1'b1, mk(2'd2, 2'd2, 24'h5));
        check(reg_rdata == 32'h0000_0005 && !expired, "R7 toggle wins", reg_rdata,
              32'h0000_0005);

        // random phase, compared against the model every cycle
        for (int k = 0; k < 20000; k++) begin
            logic [1:0] fs, ft;
            if ($urandom_range(7) == 0) begin
                fs = 2'($urandom_range(3));
                ft = 2'($urandom_range(3));
                if ($urandom_range(1) == 0) ft = ($urandom_range(1) == 0) ? 2'd1 : 2'd2;
                cyc(1'b1, mk(fs, ft, 24'($urandom_range(2))));
            end else begin
                cyc(1'b0, reg_wdata);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule